// File: doc/BRIEF.md
# Execution-Trace Write-Back Instruction Cache

A direct-mapped first-level instruction cache whose lines carry the two status bits a data cache uses, valid and dirty. When tracing is enabled, every instruction delivered to the fetch port marks its line dirty. The marked line is written back to its own memory address when it is evicted. Over time, memory therefore holds the instructions that were actually fetched for execution rather than the image that was originally loaded. No software action is involved: the cache sets the status bit and its own miss sequencer moves the data.

The fetch side is a request stream. A fetch is accepted when `fetch_valid` and `fetch_ready` are both high at a clock edge. A hit answers with `resp_valid` one cycle later. A miss drops `fetch_ready` for the whole miss sequence. The sequence first writes back a dirty victim line as four word writes, then refills the line with four word reads. The requested word is returned one cycle after the last read response. The response has no ready: the consumer must take it in the cycle it is shown. The memory side has two request streams, writes and reads, each under valid/ready back-pressure. Read data comes back on `mem_rsp_valid`, which the cache always accepts. `trace_en` is a plain control pin: with it low, the cache behaves as an ordinary read-only instruction cache for the fetches made.

Top module: `trace_icache`

## Requirements
- R1: After reset every line is invalid and clean. `fetch_ready` is high, `resp_valid` and both memory request valids are low, and the first fetch to any line misses.
- R2: A fetch that hits returns `resp_valid` high in the cycle after acceptance, with the memory word at that address on `resp_data`.
- R3: Address split: bits [1:0] are ignored, bits [3:2] select the word within a four-word line, the next log2(LINES) bits select the line, and the remaining upper bits form the tag.
- R4: With `trace_en` high at acceptance, a fetch marks its line dirty, whether it hits or refills.
- R5: A miss whose victim line is valid and dirty first issues four writes to the victim's address, words 0 to 3 in ascending order, carrying the words the line holds. All four complete before the first read request.
- R6: A miss whose victim line is invalid or clean issues no write.
- R7: A refill issues four read requests for words 0 to 3 in ascending order, each after the previous response. `fetch_ready` stays low from acceptance of the missing fetch until the requested word is returned, one cycle after the last read response.
- R8: With `trace_en` low at acceptance, a hit leaves the line's dirty bit unchanged, and a refill leaves the line clean.
- R9: A memory write or read request holds its valid, address and data stable until the matching ready is seen.
- R10: Exactly one response is given per accepted fetch, and no response appears at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | When high, accepted fetches mark their line dirty |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_ready | output | 1 | Cache can accept a fetch |
| resp_valid | output | 1 | Instruction word valid, one cycle |
| resp_data | output | 32 | Instruction word |
| mem_wr_valid | output | 1 | Write-back word request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Write word address |
| mem_wr_data | output | 32 | Write word data |
| mem_rd_valid | output | 1 | Refill read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | ADDR_W | Read word address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word |

## Verification
The hardest situations to reach are a refill with tracing off, which leaves a clean valid line, followed by an eviction of that line, and a hit with tracing off on a line that is already dirty. Both require a precise order of fetches with a chosen `trace_en` on a single line index. A directed prologue builds these orders on lines 0 and 1: cold miss, hits, dirty eviction, clean refill, clean eviction, and re-marking by a hit. A long random phase follows over a small address window. It forces frequent conflicts under random `trace_en`, random memory ready and random read latency, and a behavioural model predicts every response and memory transaction cycle by cycle.

// File: rtl/trace_icache_pkg.sv
package trace_icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_RREQ  = 2'd2,
    ST_RWAIT = 2'd3
  } ctrl_state_e;
endpackage

// File: rtl/trace_icache_status.sv
module trace_icache_status #(
  parameter int LINES = 16,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic             line_valid,
  output logic             line_dirty,
  output logic [TAG_W-1:0] line_tag,
  input  logic             mark_dirty,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= fill_dirty;
    end else if (mark_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end

  assign line_valid = valid_q[idx];
  assign line_dirty = dirty_q[idx];
  assign line_tag   = tag_q[idx];
endmodule

// File: rtl/trace_icache_data.sv
module trace_icache_data #(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_word,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] line_q [LINES][WORDS];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (wr_en && idx == IDX_W'(l)) line_q[l][wr_word] <= wr_data;
    end
  end

  assign rd_data = line_q[idx][rd_word];
endmodule

// File: rtl/trace_icache_ctrl.sv
module trace_icache_ctrl
  import trace_icache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic              lk_valid,
  input  logic              lk_dirty,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic [OFF_W-1:0]  rd_word,
  input  logic [DATA_W-1:0] rd_data,
  output logic              mark_dirty,
  output logic              fill_en,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              fill_dirty,
  output logic              dw_en,
  output logic [OFF_W-1:0]  dw_word,
  output logic [DATA_W-1:0] dw_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

  ctrl_state_e      state_q;
  logic [OFF_W-1:0] r_off, wcnt;
  logic [IDX_W-1:0] r_idx;
  logic [TAG_W-1:0] r_tag;
  logic             r_en;

  logic [OFF_W-1:0] f_off;
  logic [IDX_W-1:0] f_idx;
  logic [TAG_W-1:0] f_tag;
  logic             unused_low;
  logic             idle, accept, hit, last_rsp;

  assign f_off      = fetch_addr[OFF_W+1:2];
  assign f_idx      = fetch_addr[OFF_W+2+IDX_W-1:OFF_W+2];
  assign f_tag      = fetch_addr[ADDR_W-1:ADDR_W-TAG_W];
  assign unused_low = ^fetch_addr[1:0];

  assign idle     = (state_q == ST_IDLE);
  assign accept   = idle && fetch_valid;
  assign hit      = lk_valid && (lk_tag == f_tag);
  assign last_rsp = (state_q == ST_RWAIT) && mem_rsp_valid && (wcnt == LAST);

  assign fetch_ready = idle;
  assign lk_idx      = idle ? f_idx : r_idx;
  assign rd_word     = (state_q == ST_WBACK) ? wcnt : (idle ? f_off : r_off);

  assign mark_dirty = accept && hit && trace_en;
  assign fill_en    = last_rsp;
  assign fill_tag   = r_tag;
  assign fill_dirty = r_en;
  assign dw_en      = (state_q == ST_RWAIT) && mem_rsp_valid;
  assign dw_word    = wcnt;
  assign dw_data    = mem_rsp_data;

  assign mem_wr_valid = (state_q == ST_WBACK);
  assign mem_wr_addr  = {lk_tag, r_idx, wcnt, 2'b00};
  assign mem_wr_data  = rd_data;
  assign mem_rd_valid = (state_q == ST_RREQ);
  assign mem_rd_addr  = {r_tag, r_idx, wcnt, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_data  <= '0;
      wcnt       <= '0;
      r_off      <= '0;
      r_idx      <= '0;
      r_tag      <= '0;
      r_en       <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (hit) begin
            resp_valid <= 1'b1;
            resp_data  <= rd_data;
          end else begin
            r_off   <= f_off;
            r_idx   <= f_idx;
            r_tag   <= f_tag;
            r_en    <= trace_en;
            wcnt    <= '0;
            state_q <= (lk_valid && lk_dirty) ? ST_WBACK : ST_RREQ;
          end
        end
        ST_WBACK: if (mem_wr_ready) begin
          if (wcnt == LAST) begin
            wcnt    <= '0;
            state_q <= ST_RREQ;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_RREQ: if (mem_rd_ready) state_q <= ST_RWAIT;
        ST_RWAIT: if (mem_rsp_valid) begin
          if (wcnt == LAST) begin
            resp_valid <= 1'b1;
            resp_data  <= (r_off == LAST) ? mem_rsp_data : rd_data;
            wcnt       <= '0;
            state_q    <= ST_IDLE;
          end else begin
            wcnt    <= wcnt + 1'b1;
            state_q <= ST_RREQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trace_icache.sv
module trace_icache #(
  parameter int ADDR_W = 32,
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W - 2;

  logic [IDX_W-1:0]  lk_idx;
  logic              lk_valid, lk_dirty;
  logic [TAG_W-1:0]  lk_tag;
  logic [OFF_W-1:0]  rd_word, dw_word;
  logic [DATA_W-1:0] rd_data, dw_data;
  logic              mark_dirty, fill_en, fill_dirty, dw_en;
  logic [TAG_W-1:0]  fill_tag;

  trace_icache_status #(.LINES(LINES), .TAG_W(TAG_W)) u_status (
    .clk(clk), .rst_n(rst_n), .idx(lk_idx),
    .line_valid(lk_valid), .line_dirty(lk_dirty), .line_tag(lk_tag),
    .mark_dirty(mark_dirty), .fill_en(fill_en),
    .fill_tag(fill_tag), .fill_dirty(fill_dirty)
  );

  trace_icache_data #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .idx(lk_idx), .wr_en(dw_en), .wr_word(dw_word),
    .wr_data(dw_data), .rd_word(rd_word), .rd_data(rd_data)
  );

  trace_icache_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS),
                      .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .resp_valid(resp_valid), .resp_data(resp_data),
    .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_dirty(lk_dirty), .lk_tag(lk_tag),
    .rd_word(rd_word), .rd_data(rd_data),
    .mark_dirty(mark_dirty), .fill_en(fill_en), .fill_tag(fill_tag),
    .fill_dirty(fill_dirty), .dw_en(dw_en), .dw_word(dw_word), .dw_data(dw_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );
endmodule

// File: rtl/trace_icache_chk.sv
module trace_icache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic              resp_valid,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [ADDR_W-1:0] mem_rd_addr
);
  AST_WB_EXCLUDES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_valid && mem_rd_valid)); // R5

  AST_STALL_DURING_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid || mem_rd_valid) |-> !fetch_ready); // R7

  AST_ACCEPT_THEN_RESP_OR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready) |=> (resp_valid || !fetch_ready)); // R2

  AST_RESP_ONLY_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> fetch_ready); // R10

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R9

  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R9
endmodule

bind trace_icache trace_icache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
  .resp_valid(resp_valid), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr)
);

// File: tb/trace_icache_test.sv
module trace_icache_test;
  localparam int NL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trace_en = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_ready, resp_valid;
  logic [31:0] resp_data;
  logic        mem_wr_valid, mem_rd_valid;
  logic        mem_wr_ready = 1'b0, mem_rd_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_wr_addr, mem_wr_data, mem_rd_addr;
  logic [31:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  trace_icache #(.LINES(NL)) uut (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .resp_valid(resp_valid), .resp_data(resp_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] memf(input logic [31:0] a);
    return ((a & ~32'h3) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // stimulus: queue of fetches
  logic [31:0] op_addr[$];
  bit          op_en[$];

  // reference model state
  bit          m_valid[NL], m_dirty[NL];
  logic [31:0] m_tag[NL];
  bit          run = 0, busy = 0, exp_resp = 0, holding = 0;
  logic [31:0] exp_data, miss_addr;
  bit          miss_en;
  int          reads_done, accepted = 0, responses = 0;
  logic [31:0] wq[$], rq[$];
  bit          pend_act = 0;
  int          pend_cnt;
  logic [31:0] pend_addr;
  bit          prev_wr_stall = 0, prev_rd_stall = 0;
  logic [31:0] prev_wr_addr, prev_wr_data, prev_rd_addr;

  always @(negedge clk) begin
    if (run) begin
      // 1. compare outputs against the model
      chk(resp_valid == exp_resp, "R10 resp_valid", 32'(resp_valid), 32'(exp_resp));
      if (exp_resp && resp_valid) begin
        responses++;
        chk(resp_data == exp_data, "R2 R3 resp_data", resp_data, exp_data);
      end
      chk(fetch_ready == !busy, "R7 fetch_ready", 32'(fetch_ready), 32'(!busy));
      if (!busy)
        chk(!mem_wr_valid && !mem_rd_valid, "R1 idle memory quiet",
            32'({mem_wr_valid, mem_rd_valid}), 32'h0);
      if (mem_rd_valid)
        chk(wq.size() == 0, "R5 read before write-back done", 32'(wq.size()), 32'h0);
      if (prev_wr_stall)
        chk(mem_wr_valid && mem_wr_addr == prev_wr_addr && mem_wr_data == prev_wr_data,
            "R9 write held", mem_wr_addr, prev_wr_addr);
      if (prev_rd_stall)
        chk(mem_rd_valid && mem_rd_addr == prev_rd_addr, "R9 read held",
            mem_rd_addr, prev_rd_addr);
      exp_resp = 0;

      // 2. drive inputs
      if (!holding && op_addr.size() != 0 && ($urandom % 4) != 0) begin
        fetch_valid = 1'b1;
        fetch_addr  = op_addr[0];
        trace_en    = op_en[0];
        holding     = 1;
      end else if (!holding) begin
        fetch_valid = 1'b0;
        trace_en    = $urandom % 2;
      end
      mem_wr_ready = ($urandom % 3) != 0;
      mem_rd_ready = ($urandom % 3) != 0;
      mem_rsp_valid = 1'b0;
      if (pend_act) begin
        if (pend_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = memf(pend_addr);
          pend_act      = 0;
        end else pend_cnt--;
      end

      // 3. handshakes at the coming edge
      prev_wr_stall = mem_wr_valid && !mem_wr_ready;
      prev_wr_addr  = mem_wr_addr;
      prev_wr_data  = mem_wr_data;
      prev_rd_stall = mem_rd_valid && !mem_rd_ready;
      prev_rd_addr  = mem_rd_addr;

      if (fetch_valid && fetch_ready) begin
        logic [31:0] a;
        int ix;
        a  = fetch_addr;
        ix = int'((a >> 4) % NL);
        accepted++;
        void'(op_addr.pop_front());
        void'(op_en.pop_front());
        holding = 0;
        if (m_valid[ix] && m_tag[ix] == (a >> 8)) begin
          exp_resp = 1;
          exp_data = memf(a);
          if (trace_en) m_dirty[ix] = 1;  // R4; with trace_en low the bit stays (R8)
        end else begin
          busy = 1;
          miss_addr = a;
          miss_en = trace_en;
          reads_done = 0;
          if (m_valid[ix] && m_dirty[ix])
            for (int w = 0; w < 4; w++)
              wq.push_back((m_tag[ix] << 8) | (32'(ix) << 4) | 32'(w * 4));
          for (int w = 0; w < 4; w++) rq.push_back((a & ~32'hF) + 32'(w * 4));
        end
      end

      if (mem_wr_valid && mem_wr_ready) begin
        if (wq.size() == 0) chk(0, "R6 R8 unexpected write", mem_wr_addr, 32'h0);
        else begin
          chk(mem_wr_addr == wq[0], "R5 write address", mem_wr_addr, wq[0]);
          chk(mem_wr_data == memf(wq[0]), "R5 write data", mem_wr_data, memf(wq[0]));
          void'(wq.pop_front());
        end
      end

      if (mem_rd_valid && mem_rd_ready) begin
        if (rq.size() == 0) chk(0, "R7 unexpected read", mem_rd_addr, 32'h0);
        else begin
          chk(mem_rd_addr == rq[0], "R7 read address", mem_rd_addr, rq[0]);
          void'(rq.pop_front());
        end
        pend_act  = 1;
        pend_cnt  = $urandom % 3;
        pend_addr = mem_rd_addr;
      end

      if (mem_rsp_valid) begin
        reads_done++;
        if (reads_done == 4) begin
          int ix;
          ix = int'((miss_addr >> 4) % NL);
          m_valid[ix] = 1;
          m_tag[ix]   = miss_addr >> 8;
          m_dirty[ix] = miss_en;
          exp_resp = 1;
          exp_data = memf(miss_addr);
          busy = 0;
        end
      end
    end
  end

  task automatic push_op(input logic [31:0] a, input bit en);
    op_addr.push_back(a);
    op_en.push_back(en);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin
      m_valid[i] = 0;
      m_dirty[i] = 0;
      m_tag[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(fetch_ready == 1'b1, "R1 ready after reset", 32'(fetch_ready), 32'h1);
    chk(resp_valid == 1'b0, "R1 no response after reset", 32'(resp_valid), 32'h0);
    chk(!mem_wr_valid && !mem_rd_valid, "R1 no memory request after reset",
        32'({mem_wr_valid, mem_rd_valid}), 32'h0);
    // directed orderings on lines 0 and 1
    push_op(32'h0000_0100, 1);  // R1 R6 cold miss, line 0 traced
    push_op(32'h0000_0104, 1);  // R2 hit
    push_op(32'h0000_010B, 0);  // R3 low bits ignored, R8 dirty kept
    push_op(32'h0000_0900, 1);  // R5 dirty victim written back
    push_op(32'h0000_020C, 0);  // R5 write-back, refill clean (R8)
    push_op(32'h0000_0200, 0);  // R8 hit leaves clean
    push_op(32'h0000_0300, 1);  // R6 clean victim, no write
    push_op(32'h0000_0310, 0);  // line 1 clean refill
    push_op(32'h0000_0314, 1);  // R4 hit marks dirty
    push_op(32'h0000_0410, 0);  // R4 write-back of marked line
    push_op(32'h0000_041C, 0);
    for (int i = 0; i < 600; i++)
      push_op($urandom % 32'h1000, bit'($urandom % 2));
    run = 1;
    wait (op_addr.size() == 0 && !busy);
    repeat (8) @(negedge clk);
    chk(responses == accepted, "R10 response count", 32'(responses), 32'(accepted));
    chk(wq.size() == 0 && rq.size() == 0, "R7 outstanding memory transfers",
        32'(wq.size() + rq.size()), 32'h0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finish_run();
  end
endmodule